// File: doc/BRIEF.md
# Save-Memory Window with Device Auto-Detection

This block sits between a CPU bus and a cartridge's battery-backed save storage. It claims accesses that fall inside an adjustable, inclusive address window. It works out from the first accesses whether the storage behind that window is a plain byte RAM or a serial EEPROM. Byte, word and long requests arrive with a 24-bit address.

In RAM mode, requests are served from an internal byte memory built as four block-RAM lanes. In EEPROM mode, reads return a byte from an external serial engine. Writes in EEPROM mode are collected into a pending line value. That value is handed to the serial engine only when enough bus cycles have passed since the last hand-off. A sticky flag records that the save contents were modified.

The status register uses fixed bit positions, since the detection logic and software both decode it:
- bit 0: RAM enable
- bit 1: write lock
- bit 2: EEPROM mode
- bit 4: device type known

Other bits are kept as loaded.

Top module: `savemem_window`

## Requirements
- R1: While `rst` is high, the status register loads `cfg_status`, the window loads its configured bounds (default 0x200000 to 0x2000FF), and the modified flag clears; no read response is produced during reset.
- R2: A read is claimed only when `win_lo` <= address <= `win_hi` and status bit 0 or bit 2 is set. Every read gets exactly one response two clock edges after it is sampled, with `rsp_hit` low and data zero when it is not claimed.
- R3: A claimed read, while bit 4 is clear and bit 0 is set, marks the type known (sets bit 4) when its address is above 0x200001. A read at 0x200001 or below leaves the status unchanged.
- R4: A write inside the window sets bit 4 when bit 4 was clear. If that write's address, with bit 0 forced to zero, equals 0x200000, it also sets bit 2 and narrows the window to 0x200000 to 0x200001. A write while the type is unknown that misses the base leaves the window unchanged.
- R5: A byte write in RAM mode (bit 2 clear) stores `req_wdata[7:0]` at the addressed byte only when bit 1 is clear. With bit 1 set, the memory keeps its contents.
- R6: A byte write that stores sets the modified flag only when the new byte differs from the byte already held. Once set, the flag stays set until reset.
- R7: A word write (`req_size` 1) when bits 4, 2 and 1 read 1, 0 and 0 stores `req_wdata[15:8]` at the even address and `req_wdata[7:0]` at the next byte, and always sets the modified flag. Any other word write is handled as a byte write of `req_wdata[7:0]`.
- R8: A long write (`req_size` 2 or 3) under the same condition as R7 stores the four bytes of `req_wdata`, most significant first, from the even address upward, and sets the modified flag. Otherwise it is handled as a byte write.
- R9: A claimed byte or word read returns {16'h0, b, b}, where b is the byte at the read address (even address for words). A claimed long read returns {b0, b0, b2, b2}, taken from the even address and the even address + 2. In EEPROM mode every b is `eep_rdata` as sampled with the request.
- R10: In EEPROM mode, a write arriving when `cyc_now` minus the last hand-off stamp is below 46 only replaces the pending byte. Otherwise `eep_wr_valid` pulses for one cycle, one edge later, carrying the previous pending byte. The new byte becomes pending and the stamp reloads. After reset the pending byte and the stamp are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_status | input | 8 | Status value loaded during reset |
| cyc_now | input | 16 | Free-running bus cycle count used as timestamp |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for byte and word |
| eep_rdata | input | 8 | Read byte from the serial EEPROM engine |
| rsp_valid | output | 1 | Read response strobe |
| rsp_hit | output | 1 | Read was claimed by the window |
| rsp_rdata | output | 32 | Read data |
| eep_wr_valid | output | 1 | One-cycle hand-off of the pending line byte |
| eep_wr_data | output | 8 | Pending byte handed to the serial engine |
| stat_q | output | 8 | Status register |
| win_lo | output | 24 | Window lower bound, inclusive |
| win_hi | output | 24 | Window upper bound, inclusive |
| dirty | output | 1 | Save contents modified flag |

## Verification
The bench probes the detection boundary with reads at 0x200001 and 0x200002. A design that compared with >= would mark the type known one address early. It writes a byte equal to the stored one after a reset that leaves memory intact. A design that flagged every write would raise the modified flag there. A long read at an address two below a lane-row boundary catches lane rows that fail to advance, which would return the wrong second pair. EEPROM writes at exactly 45 and 46 cycles after a hand-off expose an off-by-one in the spacing compare, which would shift or drop a hand-off.

// File: rtl/smw_pkg.sv
package smw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONGX = 2'd3
  } acc_size_e;

  // status register bit positions (decoded by software and detection)
  localparam int ST_RAM_EN = 0;
  localparam int ST_WR_LCK = 1;
  localparam int ST_EEP    = 2;
  localparam int ST_KNOWN  = 4;

  localparam int LANES = 4;

endpackage

// File: rtl/smw_bank.sv
module smw_bank #(
  parameter int ROWS   = 64,
  parameter int ROW_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ROW_AW-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] mem [ROWS];

  initial begin
    for (int i = 0; i < ROWS; i++) mem[i] = 8'h00;
  end

  // read-first single-port style: a read at the written row returns old data
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/smw_ctrl.sv
module smw_ctrl
  import smw_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                CYC_W       = 16,
  parameter int                EEP_GAP     = 46,
  parameter logic [ADDR_W-1:0] EEP_BASE    = 24'h200000,
  parameter logic [ADDR_W-1:0] WIN_LO_INIT = 24'h200000,
  parameter logic [ADDR_W-1:0] WIN_HI_INIT = 24'h2000FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cfg_status,
  input  logic [CYC_W-1:0]  cyc_now,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        wbyte,
  output logic [7:0]        stat_q,
  output logic [ADDR_W-1:0] win_lo_q,
  output logic [ADDR_W-1:0] win_hi_q,
  output logic              rd_hit,
  output logic              rd_eep,
  output logic              st_en,
  output logic              st_byte,
  output logic              eep_wr_valid,
  output logic [7:0]        eep_wr_data
);

  localparam logic [ADDR_W-1:0] EEP_TOP = EEP_BASE + ADDR_W'(1);
  localparam logic [CYC_W-1:0]  GAP_C   = CYC_W'(EEP_GAP);

  logic              in_win, wr_hit, fast_wr, slow_wr, eep_req;
  logic              rd_detect, wr_detect, wr_base, gap_open;
  logic [CYC_W-1:0]  last_q, delta;
  logic [7:0]        pend_q;

  assign in_win  = (req_addr >= win_lo_q) && (req_addr <= win_hi_q);
  assign wr_hit  = req_valid && req_write && in_win;
  assign rd_hit  = req_valid && !req_write && in_win &&
                   (stat_q[ST_RAM_EN] || stat_q[ST_EEP]);
  assign rd_eep  = stat_q[ST_EEP];

  // multi-byte stores take the direct path only on a known, unlocked RAM
  assign fast_wr = (req_size != SZ_BYTE) && stat_q[ST_KNOWN] &&
                   !stat_q[ST_EEP] && !stat_q[ST_WR_LCK];
  assign slow_wr = wr_hit && !fast_wr;
  assign st_en   = wr_hit && !stat_q[ST_EEP] && !stat_q[ST_WR_LCK];
  assign st_byte = !fast_wr;
  assign eep_req = slow_wr && stat_q[ST_EEP];

  assign rd_detect = rd_hit && !stat_q[ST_KNOWN] && stat_q[ST_RAM_EN] &&
                     (req_addr > EEP_TOP);
  assign wr_detect = slow_wr && !stat_q[ST_KNOWN];
  assign wr_base   = ({req_addr[ADDR_W-1:1], 1'b0} == EEP_BASE);

  assign delta    = cyc_now - last_q;
  assign gap_open = (delta >= GAP_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q       <= cfg_status;
      win_lo_q     <= WIN_LO_INIT;
      win_hi_q     <= WIN_HI_INIT;
      last_q       <= '0;
      pend_q       <= '0;
      eep_wr_valid <= 1'b0;
      eep_wr_data  <= '0;
    end else begin
      eep_wr_valid <= 1'b0;
      if (rd_detect) stat_q[ST_KNOWN] <= 1'b1;
      if (wr_detect) begin
        stat_q[ST_KNOWN] <= 1'b1;
        if (wr_base) begin
          stat_q[ST_EEP] <= 1'b1;
          win_lo_q       <= EEP_BASE;
          win_hi_q       <= EEP_TOP;
        end
      end
      if (eep_req) begin
        pend_q <= wbyte;
        if (gap_open) begin
          eep_wr_valid <= 1'b1;
          eep_wr_data  <= pend_q;
          last_q       <= cyc_now;
        end
      end
    end
  end

endmodule

// File: rtl/smw_rsp.sv
module smw_rsp
  import smw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 p_rd,
  input  logic                 p_hit,
  input  logic                 p_eep,
  input  logic [7:0]           p_eepdat,
  input  logic                 p_long,
  input  logic [1:0]           p_lane0,
  input  logic [8*LANES-1:0]   lanes,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [31:0]          rsp_rdata
);

  logic [7:0]  b0, b2;
  logic [1:0]  lane2;
  logic [31:0] fmt;

  assign lane2 = p_lane0 + 2'd2;
  assign b0    = p_eep ? p_eepdat : lanes[{p_lane0, 3'b000} +: 8];
  assign b2    = p_eep ? p_eepdat : lanes[{lane2, 3'b000} +: 8];

  always_comb begin
    if (!p_hit)      fmt = '0;
    else if (p_long) fmt = {b0, b0, b2, b2};
    else             fmt = {16'h0000, b0, b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= p_rd;
      rsp_hit   <= p_rd && p_hit;
      rsp_rdata <= p_rd ? fmt : '0;
    end
  end

endmodule

// File: rtl/savemem_window.sv
module savemem_window
  import smw_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                CYC_W       = 16,
  parameter int                RAM_BYTES   = 256,
  parameter int                EEP_GAP     = 46,
  parameter logic [ADDR_W-1:0] EEP_BASE    = 24'h200000,
  parameter logic [ADDR_W-1:0] WIN_LO_INIT = 24'h200000,
  parameter logic [ADDR_W-1:0] WIN_HI_INIT = 24'h2000FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cfg_status,
  input  logic [CYC_W-1:0]  cyc_now,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [7:0]        eep_rdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_rdata,
  output logic              eep_wr_valid,
  output logic [7:0]        eep_wr_data,
  output logic [7:0]        stat_q,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi,
  output logic              dirty
);

  localparam int RAM_AW = $clog2(RAM_BYTES);
  localparam int ROW_AW = RAM_AW - 2;
  localparam int ROWS   = RAM_BYTES / LANES;

  logic              rd_hit, rd_eep, st_en, st_byte;
  logic [RAM_AW-1:0] off, base;
  logic [2:0]        wspan;
  logic              byte_base;
  logic [8*LANES-1:0] lane_q;

  // stage-1 pipeline state
  logic       p_rd, p_hit, p_eep, p_long, p_cmp;
  logic [7:0] p_eepdat, p_cmp_val;
  logic [1:0] p_lane0, p_cmp_lane;

  smw_ctrl #(
    .ADDR_W(ADDR_W), .CYC_W(CYC_W), .EEP_GAP(EEP_GAP), .EEP_BASE(EEP_BASE),
    .WIN_LO_INIT(WIN_LO_INIT), .WIN_HI_INIT(WIN_HI_INIT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cfg_status(cfg_status), .cyc_now(cyc_now),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .wbyte(req_wdata[7:0]),
    .stat_q(stat_q), .win_lo_q(win_lo), .win_hi_q(win_hi),
    .rd_hit(rd_hit), .rd_eep(rd_eep), .st_en(st_en), .st_byte(st_byte),
    .eep_wr_valid(eep_wr_valid), .eep_wr_data(eep_wr_data)
  );

  // offset into the save memory, relative to the current lower bound
  assign off       = req_addr[RAM_AW-1:0] - win_lo[RAM_AW-1:0];
  assign byte_base = req_write ? st_byte : (req_size == SZ_BYTE);
  assign base      = byte_base ? off : {off[RAM_AW-1:1], 1'b0};

  always_comb begin
    if (st_byte)                 wspan = 3'd1;
    else if (req_size == SZ_WORD) wspan = 3'd2;
    else                          wspan = 3'd4;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0]        dk, idx;
    logic [RAM_AW-1:0] ok;
    logic [ROW_AW-1:0] row;
    logic              we;
    logic [7:0]        wd;

    assign dk  = 2'(k) - base[1:0];
    assign ok  = base + RAM_AW'(dk);
    assign row = ok[RAM_AW-1:2];
    assign we  = st_en && ({1'b0, dk} < wspan);
    assign idx = (req_size == SZ_WORD) ? dk + 2'd2 : dk;
    assign wd  = st_byte ? req_wdata[7:0] : req_wdata[{~idx, 3'b000} +: 8];

    smw_bank #(.ROWS(ROWS), .ROW_AW(ROW_AW)) bank_i (
      .clk(clk), .we(we), .waddr(row), .wdata(wd),
      .raddr(row), .rdata(lane_q[8*k +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_rd       <= 1'b0;
      p_hit      <= 1'b0;
      p_eep      <= 1'b0;
      p_eepdat   <= '0;
      p_long     <= 1'b0;
      p_lane0    <= '0;
      p_cmp      <= 1'b0;
      p_cmp_val  <= '0;
      p_cmp_lane <= '0;
      dirty      <= 1'b0;
    end else begin
      p_rd       <= req_valid && !req_write;
      p_hit      <= rd_hit;
      p_eep      <= rd_eep;
      p_eepdat   <= eep_rdata;
      p_long     <= req_size[1];
      p_lane0    <= base[1:0];
      p_cmp      <= st_en && st_byte;
      p_cmp_val  <= req_wdata[7:0];
      p_cmp_lane <= off[1:0];
      if ((st_en && !st_byte) ||
          (p_cmp && (lane_q[{p_cmp_lane, 3'b000} +: 8] != p_cmp_val)))
        dirty <= 1'b1;
    end
  end

  smw_rsp rsp_i (
    .clk(clk), .rst(rst), .p_rd(p_rd), .p_hit(p_hit), .p_eep(p_eep),
    .p_eepdat(p_eepdat), .p_long(p_long), .p_lane0(p_lane0), .lanes(lane_q),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/smw_chk.sv
module smw_chk #(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] EEP_BASE = 24'h200000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              st_known,
  input logic              st_eep,
  input logic [ADDR_W-1:0] win_lo,
  input logic [ADDR_W-1:0] win_hi,
  input logic              dirty,
  input logic              eep_wr_valid
);

  // R2
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write, 2));

  // R2
  hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R2
  win_order_chk: assert property (@(posedge clk) disable iff (rst)
    win_lo <= win_hi);

  // R3
  known_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(st_known) |-> st_known);

  // R4
  narrow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_eep) |-> (win_lo == EEP_BASE) && (win_hi == EEP_BASE + ADDR_W'(1)));

  // R6
  dirty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dirty) |-> dirty);

  // R10
  eep_mode_chk: assert property (@(posedge clk) disable iff (rst)
    eep_wr_valid |-> $past(st_eep));

endmodule

bind savemem_window smw_chk #(.ADDR_W(ADDR_W), .EEP_BASE(EEP_BASE)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .st_known(stat_q[4]), .st_eep(stat_q[2]),
  .win_lo(win_lo), .win_hi(win_hi), .dirty(dirty),
  .eep_wr_valid(eep_wr_valid)
);

// File: tb/savemem_window_tb_top.sv
module savemem_window_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_status = 8'h01;
  logic [15:0] cyc = 16'd0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  eep_rdata = 8'hC3;
  logic        rsp_valid, rsp_hit, eep_wr_valid, dirty;
  logic [31:0] rsp_rdata;
  logic [7:0]  eep_wr_data, stat_q;
  logic [23:0] win_lo, win_hi;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 16'd1;

  savemem_window dut_i (
    .clk(clk), .rst(rst), .cfg_status(cfg_status), .cyc_now(cyc),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .eep_rdata(eep_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .eep_wr_valid(eep_wr_valid), .eep_wr_data(eep_wr_data),
    .stat_q(stat_q), .win_lo(win_lo), .win_hi(win_hi), .dirty(dirty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read responses as they appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", 32'h1, 32'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " hit"}, {31'b0, rsp_hit}, {31'b0, e[32]});
        check({t, " data"}, rsp_rdata, e[31:0]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(input logic wr, input logic [1:0] sz, input logic [23:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sz, input logic [23:0] a,
                    input logic hit, input logic [31:0] d);
    exp_q.push_back({hit, d});
    tag_q.push_back(tag);
    do_req(1'b0, sz, a, 32'h0);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [23:0] a, input logic [31:0] d);
    do_req(1'b1, sz, a, d);
  endtask

  task automatic do_reset(input logic [7:0] cfg);
    idle(3);
    rst = 1'b1; cfg_status = cfg;
    idle(4);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic eep_wr_at(input logic [15:0] t, input logic [7:0] d,
                           input logic exp_v, input logic [7:0] exp_d);
    while (cyc != t) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
    req_addr = 24'h200001; req_wdata = {24'h0, d};
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10 hand-off strobe", {31'b0, eep_wr_valid}, {31'b0, exp_v});
    if (exp_v) check("R10 hand-off byte", {24'b0, eep_wr_data}, {24'b0, exp_d});
  endtask

  initial begin
    logic [15:0] t1;
    // phase 1: RAM enabled, type unknown
    do_reset(8'h01);
    check("R1 status", {24'b0, stat_q}, 32'h01);
    check("R1 win_lo", {8'b0, win_lo}, 32'h200000);
    check("R1 win_hi", {8'b0, win_hi}, 32'h2000FF);
    check("R1 dirty", {31'b0, dirty}, 32'h0);
    check("R1 no response", {31'b0, rsp_valid}, 32'h0);
    rd("R3 read at boundary", 2'd0, 24'h200001, 1'b1, 32'h0);
    check("R3 boundary keeps status", {24'b0, stat_q}, 32'h01);
    rd("R3 read above boundary", 2'd0, 24'h200002, 1'b1, 32'h0);
    check("R3 detect by read", {24'b0, stat_q}, 32'h11);
    idle(2);
    check("R6 clean before write", {31'b0, dirty}, 32'h0);
    wr(2'd0, 24'h200005, 32'h5A);
    idle(1);
    check("R6 differing byte", {31'b0, dirty}, 32'h1);
    rd("R5 R9 byte read back", 2'd0, 24'h200005, 1'b1, 32'h00005A5A);
    wr(2'd1, 24'h200010, 32'hBEEF);
    rd("R7 low byte", 2'd0, 24'h200011, 1'b1, 32'h0000EFEF);
    rd("R7 R9 word read", 2'd1, 24'h200010, 1'b1, 32'h0000BEBE);
    wr(2'd2, 24'h200020, 32'h11223344);
    wr(2'd0, 24'h200024, 32'h77);
    rd("R8 R9 long read", 2'd2, 24'h200020, 1'b1, 32'h11113333);
    rd("R9 long read across row", 2'd2, 24'h200022, 1'b1, 32'h33337777);
    rd("R8 last byte", 2'd0, 24'h200023, 1'b1, 32'h00004444);
    rd("R2 above window", 2'd0, 24'h200100, 1'b0, 32'h0);
    rd("R2 below window", 2'd0, 24'h1FFFFF, 1'b0, 32'h0);
    rd("R2 top edge", 2'd0, 24'h2000FF, 1'b1, 32'h0);

    // phase 2: memory kept, flag cleared
    do_reset(8'h11);
    check("R1 dirty after reset", {31'b0, dirty}, 32'h0);
    wr(2'd0, 24'h200005, 32'h5A);
    idle(1);
    check("R6 equal byte", {31'b0, dirty}, 32'h0);
    wr(2'd0, 24'h200005, 32'h5B);
    idle(1);
    check("R6 new byte", {31'b0, dirty}, 32'h1);

    // phase 3: write lock
    do_reset(8'h13);
    wr(2'd0, 24'h200005, 32'h00);
    wr(2'd1, 24'h200010, 32'h0000);
    idle(1);
    check("R5 locked flag", {31'b0, dirty}, 32'h0);
    rd("R5 locked byte", 2'd0, 24'h200005, 1'b1, 32'h00005B5B);
    rd("R5 locked word", 2'd1, 24'h200010, 1'b1, 32'h0000BEBE);

    // phase 4: nothing enabled
    do_reset(8'h00);
    rd("R2 disabled read", 2'd0, 24'h200005, 1'b0, 32'h0);
    wr(2'd0, 24'h200008, 32'h12);
    check("R4 detect off base", {24'b0, stat_q}, 32'h10);
    check("R4 window kept", {8'b0, win_hi}, 32'h2000FF);

    // phase 5: EEPROM detection and write spacing
    do_reset(8'h01);
    wr(2'd0, 24'h200001, 32'h99);
    check("R4 eeprom status", {24'b0, stat_q}, 32'h15);
    check("R4 narrowed lo", {8'b0, win_lo}, 32'h200000);
    check("R4 narrowed hi", {8'b0, win_hi}, 32'h200001);
    check("R10 no hand-off on detect", {31'b0, eep_wr_valid}, 32'h0);
    rd("R4 outside narrow window", 2'd0, 24'h200004, 1'b0, 32'h0);
    rd("R9 eeprom byte", 2'd0, 24'h200001, 1'b1, 32'h0000C3C3);
    rd("R9 eeprom long", 2'd2, 24'h200000, 1'b1, 32'hC3C3C3C3);
    idle(2);
    t1 = cyc + 16'd5;
    eep_wr_at(t1, 8'hA1, 1'b1, 8'h00);
    eep_wr_at(t1 + 16'd45, 8'hA2, 1'b0, 8'h00);
    eep_wr_at(t1 + 16'd46, 8'hA3, 1'b1, 8'hA2);
    eep_wr_at(t1 + 16'd56, 8'hA4, 1'b0, 8'h00);
    eep_wr_at(t1 + 16'd92, 8'hA5, 1'b1, 8'hA4);

    idle(4);
    check("R2 all responses seen", exp_q.size(), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule